// File: doc/BRIEF.md
# Subtractive GCD Engine

This block computes the greatest common divisor of two unsigned operands by repeated subtraction. A one-cycle `start` pulse captures both operand inputs into working registers. On every following clock edge, the engine compares the two registers and subtracts the smaller from the larger. It stops when the registers are equal, or when either one is zero. The answer then appears on `result` and `valid` goes high.

The design is split into a datapath and a controller, joined in the top module. The datapath holds the two working registers, a magnitude comparator, the subtractors and the result register. The controller is a three-state machine (idle, computing, finished). It drives the load, update and capture strobes and owns the `valid` flag. Only one request is in flight at a time. A `start` that arrives during a computation is dropped. The answer stays on the outputs until the next accepted `start`.

Top module: `euclid_sub_engine`

## Requirements
- R1: While `rst` is high at a clock edge, `valid` and `result` are 0 after that edge and the engine is idle.
- R2: A `start` sampled high while the engine is not computing loads `a_in` and `b_in` into the working registers and begins a computation. `valid` is 0 after that edge.
- R3: On a computing cycle where the first register is larger than the second and both are nonzero, the first register is replaced by the first minus the second. The second register is unchanged.
- R4: On a computing cycle where the second register is larger than the first and both are nonzero, the second register is replaced by the second minus the first. The first register is unchanged.
- R5: On a computing cycle where the two registers are equal, the computation ends. At the next edge, `result` equals that register value and `valid` is 1. `valid` therefore rises exactly S+1 edges after the accepting edge, where S is the number of subtractions.
- R6: For any operand pair with at least one nonzero operand, `result` equals their greatest common divisor. For example, 2 and 8 give 2.
- R7: Once `valid` is 1, both `valid` and `result` hold their values, whatever `a_in` and `b_in` do, until a `start` is accepted.
- R8: A `start` sampled while a computation is running has no effect. The running result and its completion cycle are unchanged.
- R9: If either loaded operand is zero, the computation ends on the first computing cycle and returns the other operand. Two zero operands give 0.
- R10: A `start` sampled in the same cycle that `valid` is high is accepted and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; loads operands when idle or finished |
| a_in | input | W (8) | First operand |
| b_in | input | W (8) | Second operand |
| result | output | W (8) | Greatest common divisor, meaningful while `valid` is 1 |
| valid | output | 1 | High from completion until the next accepted `start` |

## Verification
Two functions can fall in the same cycle, and each collision is driven on purpose.

The first is a fresh `start` landing on a cycle when the engine is still computing, including the cycle in which it finishes. The bench raises `start` with different operands on the first computing cycle. It then judges that the answer and the completion cycle match the original request.

The second is `start` coinciding with a held `valid`. Every sweep request is issued on the cycle right after the previous answer appears, so `valid` is still high. The bench judges that `valid` drops one edge later and that the new answer arrives on time.

// File: rtl/euclid_pkg.sv
package euclid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPUTE = 2'd1,
    ST_DONE    = 2'd2
  } euclid_state_t;
endpackage

// File: rtl/euclid_cmp.sv
module euclid_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         x_zero,
  output logic         y_zero,
  output logic         equal,
  output logic         x_gt
);
  always_comb begin
    x_zero = (x == '0);
    y_zero = (y == '0);
    equal  = (x == y);
    x_gt   = (x > y);
  end
endmodule

// File: rtl/euclid_datapath.sv
module euclid_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         upd_a,
  input  logic         upd_b,
  input  logic         cap,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] opa,
  output logic [W-1:0] opb,
  output logic [W-1:0] res,
  output logic         a_zero,
  output logic         b_zero,
  output logic         eq,
  output logic         a_gt
);
  logic [W-1:0] diff_ab;
  logic [W-1:0] diff_ba;

  euclid_cmp #(.W(W)) cmp_i (
    .x      (opa),
    .y      (opb),
    .x_zero (a_zero),
    .y_zero (b_zero),
    .equal  (eq),
    .x_gt   (a_gt)
  );

  always_comb begin
    diff_ab = opa - opb;
    diff_ba = opb - opa;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opa <= '0;
      opb <= '0;
    end else if (ld) begin
      opa <= a_in;
      opb <= b_in;
    end else begin
      if (upd_a) opa <= diff_ab;
      if (upd_b) opb <= diff_ba;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      res <= '0;
    else if (cap) res <= a_zero ? opb : opa;
  end
endmodule

// File: rtl/euclid_ctrl.sv
module euclid_ctrl
  import euclid_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic a_zero,
  input  logic b_zero,
  input  logic eq,
  input  logic a_gt,
  output logic ld,
  output logic upd_a,
  output logic upd_b,
  output logic cap,
  output logic busy,
  output logic valid
);
  euclid_state_t state_q, state_d;
  logic finish;

  always_comb begin
    finish  = a_zero | b_zero | eq;
    state_d = state_q;
    ld      = 1'b0;
    upd_a   = 1'b0;
    upd_b   = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          ld      = 1'b1;
          state_d = ST_COMPUTE;
        end else if (state_q == ST_DONE) begin
          state_d = ST_IDLE;
        end
      end
      ST_COMPUTE: begin
        if (finish) begin
          cap     = 1'b1;
          state_d = ST_DONE;
        end else if (a_gt) begin
          upd_a = 1'b1;
        end else begin
          upd_b = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ld)       valid <= 1'b0;
      else if (cap) valid <= 1'b1;
    end
  end

  assign busy = (state_q == ST_COMPUTE);
endmodule

// File: rtl/euclid_sub_engine.sv
module euclid_sub_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         valid
);
  logic         ld, upd_a, upd_b, cap, busy;
  logic         a_zero, b_zero, eq, a_gt;
  logic [W-1:0] opa, opb;

  euclid_datapath #(.W(W)) dp_i (
    .clk    (clk),
    .rst    (rst),
    .ld     (ld),
    .upd_a  (upd_a),
    .upd_b  (upd_b),
    .cap    (cap),
    .a_in   (a_in),
    .b_in   (b_in),
    .opa    (opa),
    .opb    (opb),
    .res    (result),
    .a_zero (a_zero),
    .b_zero (b_zero),
    .eq     (eq),
    .a_gt   (a_gt)
  );

  euclid_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .a_zero (a_zero),
    .b_zero (b_zero),
    .eq     (eq),
    .a_gt   (a_gt),
    .ld     (ld),
    .upd_a  (upd_a),
    .upd_b  (upd_b),
    .cap    (cap),
    .busy   (busy),
    .valid  (valid)
  );
endmodule

// File: rtl/euclid_sub_engine_chk.sv
module euclid_sub_engine_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         valid,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [W-1:0] result
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!valid && result == '0 && !busy));

  assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !valid));

  assert_sub_first_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && opa > opb && opb != '0) |=>
      (opa == $past(opa) - $past(opb) && opb == $past(opb)));

  assert_sub_second_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && opb > opa && opa != '0) |=>
      (opb == $past(opb) - $past(opa) && opa == $past(opa)));

  assert_equal_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && opa == opb) |=> (valid && !busy && result == $past(opa)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (valid && !start) |=> (valid && $stable(result)));

  assert_busy_exit_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !valid) |=> (busy || valid));

  assert_zero_operand_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && (opa == '0 || opb == '0)) |=>
      (valid && result == ($past(opa) == '0 ? $past(opb) : $past(opa))));
endmodule

bind euclid_sub_engine euclid_sub_engine_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .valid  (valid),
  .opa    (opa),
  .opb    (opb),
  .result (result)
);

// File: tb/euclid_sub_engine_tb_top.sv
module euclid_sub_engine_tb_top;
  localparam int W        = 8;
  localparam int CLK_HALF = 5;
  localparam int WATCHDOG = 190000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] result;
  logic         valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  euclid_sub_engine #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .a_in(a_in), .b_in(b_in), .result(result), .valid(valid)
  );

  always #CLK_HALF clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      n_fail   = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: run did not finish, cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gcd_ref(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin
      t = x % y; x = y; y = t;
    end
    return x;
  endfunction

  function automatic int steps_ref(input int a, input int b);
    int x = a, y = b, t, s = 0;
    if (a == 0 || b == 0) return 0;
    while (y != 0) begin
      s += x / y; t = x % y; x = y; y = t;
    end
    return s - 1;
  endfunction

  task automatic run_op(input int a, input int b, input bit poke, input bit hold);
    int lat = 0;
    int exp_r = gcd_ref(a, b);
    int exp_l = steps_ref(a, b) + 1;
    bit was_valid;
    @(negedge clk);
    was_valid = valid;
    a_in = W'(a); b_in = W'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (was_valid) check(valid == 1'b0, "R10 start with valid high clears valid", int'(valid), 0);
    else           check(valid == 1'b0, "R2 valid clear after start", int'(valid), 0);
    if (poke) begin
      a_in = W'(a + 3); b_in = W'(b + 5); start = 1'b1;
    end
    while (!valid && lat < 400) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    check(int'(result) == exp_r, poke ? "R8 start during compute ignored, result" : "R6 gcd result",
          int'(result), exp_r);
    if (a == 0 || b == 0)
      check(lat == 1, "R9 zero operand finishes on first compute cycle", lat, 1);
    else
      check(lat == exp_l, "R5 R3 R4 completion cycle", lat, exp_l);
    if (hold) begin
      a_in = 8'hA5; b_in = 8'h3C;
      repeat (3) @(negedge clk);
      check(valid == 1'b1, "R7 valid held", int'(valid), 1);
      check(int'(result) == exp_r, "R7 result held", int'(result), exp_r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 1'b0, "R1 valid in reset", int'(valid), 0);
    check(result == '0, "R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R1 valid after reset", int'(valid), 0);

    run_op(2, 8, 1'b0, 1'b1);
    run_op(8, 2, 1'b0, 1'b0);
    run_op(255, 1, 1'b0, 1'b0);
    run_op(1, 255, 1'b0, 1'b0);
    run_op(255, 255, 1'b0, 1'b1);
    run_op(0, 7, 1'b0, 1'b0);
    run_op(9, 0, 1'b0, 1'b0);
    run_op(0, 0, 1'b0, 1'b0);
    run_op(210, 84, 1'b1, 1'b1);
    run_op(13, 13, 1'b1, 1'b0);

    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_op(i, j, 1'b0, 1'b0);

    for (int j = 1; j < 256; j++)
      run_op(200, j, (j % 17) == 0, 1'b0);

    // reset while finished clears outputs
    rst = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1 reset clears valid", int'(valid), 0);
    check(result == '0, "R1 reset clears result", int'(result), 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule